// File: doc/BRIEF.md
# Masked Bit Test-and-Skip Unit

This unit serves the execute stage of a 36-bit processor. It selects a group of accumulator bits through a mask and decides whether the following instruction is to be skipped. It can also clear, set or invert the selected bits in the accumulator. The mask comes from one of four places: the 18-bit effective address placed in the upper or lower half of a word, the 36-bit memory operand as it stands, or that operand with its halves exchanged.

A request is a single cycle with `req_valid` high. The accumulator, effective address, memory word and a 6-bit operation code must be valid in that cycle. One clock later the unit presents a registered result: the new accumulator value, a write-enable telling the register file whether to store it, and the skip decision. The skip test always looks at the accumulator as it was before any modification, so one request can both change the bits and skip on their old state. Updating the program counter and fetching the memory operand are left to the surrounding pipeline.

Top module: `bt_test_skip`

## Requirements
- R1: After a clock edge with `rst_n` low, `out_valid`, `acc_we` and `skip_out` are 0 and `acc_out` is all zeros.
- R2: `out_valid` is high exactly in the cycle after a cycle with `req_valid` high. All result outputs are registered, with one cycle of latency.
- R3: Mask source is `op_in[5:4]`. 0 gives {ea, 18 zeros}, 1 gives {18 zeros, ea}, 2 gives the memory word, and 3 gives {mem[17:0], mem[35:18]}.
- R4: Modification is `op_in[3:2]`. 0 passes the accumulator through unchanged, 1 gives acc AND NOT mask, 2 gives acc OR mask, and 3 gives acc XOR mask.
- R5: `acc_we` is high in a result cycle exactly when the modification code was not 0.
- R6: Skip condition is `op_in[1:0]`. Code 0 never skips and code 1 always skips.
- R7: Code 2 skips when (acc AND mask) is nonzero and code 3 skips when it is zero. The test is made on the accumulator before modification.
- R8: In a cycle after no request, `acc_we` and `skip_out` are 0 and `acc_out` keeps its previous value.
- R9: An all-zero mask leaves the accumulator unchanged under every modification. With such a mask, code 3 skips and code 2 does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per operation |
| acc_in | input | 36 | Accumulator value before the operation |
| ea_in | input | 18 | Effective address |
| mem_in | input | 36 | Memory operand word |
| op_in | input | 6 | {mask source[1:0], modification[1:0], skip condition[1:0]} |
| out_valid | output | 1 | Result valid, one cycle after a request |
| acc_out | output | 36 | Accumulator value after modification |
| acc_we | output | 1 | Accumulator write-enable |
| skip_out | output | 1 | Skip the next instruction |

## Verification
The skip decision and the bit modification resolve in the same result cycle, and both act on the same masked bits. The case that tells a correct design from a wrong one is set-bits with skip-when-zero, or clear-bits with skip-when-nonzero, on an accumulator whose masked bits start in the opposite state. Here the pre-modification value and the post-modification value give opposite skip answers. Directed requests target that conflict, and random codes across all 64 operations hit it further. In every case the bench predicts the skip from the original accumulator and the new value from the mask, and checks the two independently.

// File: rtl/bt_pkg.sv
// Package: shared encodings for the masked bit test-and-skip unit.
// Assumes the operation code is packed as {source, modification, condition}.
package bt_pkg;

    // Mask source selector, op bits [5:4]
    typedef enum logic [1:0] {
        MSRC_ADDR_HI  = 2'd0,
        MSRC_ADDR_LO  = 2'd1,
        MSRC_MEM      = 2'd2,
        MSRC_MEM_SWAP = 2'd3
    } msrc_e;

    // Bit modification selector, op bits [3:2]
    typedef enum logic [1:0] {
        MOD_KEEP  = 2'd0,
        MOD_CLEAR = 2'd1,
        MOD_SET   = 2'd2,
        MOD_FLIP  = 2'd3
    } mod_e;

    // Skip condition selector, op bits [1:0]
    typedef enum logic [1:0] {
        SKC_NEVER  = 2'd0,
        SKC_ALWAYS = 2'd1,
        SKC_ANY    = 2'd2,
        SKC_NONE   = 2'd3
    } skip_e;

    // Decoded operation; field order is the bit order of the opcode
    typedef struct packed {
        msrc_e src;
        mod_e  md;
        skip_e cond;
    } op_t;

    localparam int OP_W = $bits(op_t);

endpackage

// File: rtl/bt_mask_gen.sv
// Module: bt_mask_gen
// Builds the test mask from the effective address or the memory word.
// Assumes WORD_W is twice HALF_W. Purely combinational.
module bt_mask_gen #(
    parameter int HALF_W = 18,
    localparam int WORD_W = 2 * HALF_W
) (
    input  bt_pkg::msrc_e       src,
    input  logic [HALF_W-1:0]   ea,
    input  logic [WORD_W-1:0]   mem,
    output logic [WORD_W-1:0]   mask
);
    import bt_pkg::*;

    logic [HALF_W-1:0] zero_half;
    logic [WORD_W-1:0] mem_swapped;

    assign zero_half = '0;

    // Exchange the two halves of the memory word
    assign mem_swapped = {mem[HALF_W-1:0], mem[WORD_W-1:HALF_W]};

    // Select the mask according to the source code
    always_comb begin
        unique case (src)
            MSRC_ADDR_HI:  mask = {ea, zero_half};
            MSRC_ADDR_LO:  mask = {zero_half, ea};
            MSRC_MEM:      mask = mem;
            MSRC_MEM_SWAP: mask = mem_swapped;
            default:       mask = '0;
        endcase
    end

endmodule

// File: rtl/bt_modify.sv
// Module: bt_modify
// Applies clear, set or invert to the masked accumulator bits.
// The per-bit update is laid out by a generate loop. Purely combinational.
module bt_modify #(
    parameter int WORD_W = 36
) (
    input  bt_pkg::mod_e        md,
    input  logic [WORD_W-1:0]   acc,
    input  logic [WORD_W-1:0]   mask,
    output logic [WORD_W-1:0]   result,
    output logic                writes
);
    import bt_pkg::*;

    // Any operation other than keep produces a write-back
    assign writes = (md != MOD_KEEP);

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        // Update one accumulator bit under its mask bit
        always_comb begin
            if (!mask[b]) begin
                result[b] = acc[b];
            end else begin
                unique case (md)
                    MOD_KEEP:  result[b] = acc[b];
                    MOD_CLEAR: result[b] = 1'b0;
                    MOD_SET:   result[b] = 1'b1;
                    MOD_FLIP:  result[b] = ~acc[b];
                    default:   result[b] = acc[b];
                endcase
            end
        end
    end

endmodule

// File: rtl/bt_skip_eval.sv
// Module: bt_skip_eval
// Decides the skip from the unmodified accumulator and the mask.
// Assumes acc is the value before any bit modification. Combinational.
module bt_skip_eval #(
    parameter int WORD_W = 36
) (
    input  bt_pkg::skip_e       cond,
    input  logic [WORD_W-1:0]   acc,
    input  logic [WORD_W-1:0]   mask,
    output logic                skip
);
    import bt_pkg::*;

    logic [WORD_W-1:0] tested;
    logic              any_set;

    // Isolate the bits under test and reduce them
    assign tested  = acc & mask;
    assign any_set = |tested;

    // Map the condition code onto the reduced test
    always_comb begin
        unique case (cond)
            SKC_NEVER:  skip = 1'b0;
            SKC_ALWAYS: skip = 1'b1;
            SKC_ANY:    skip = any_set;
            SKC_NONE:   skip = ~any_set;
            default:    skip = 1'b0;
        endcase
    end

endmodule

// File: rtl/bt_test_skip.sv
// Module: bt_test_skip (top)
// Masked bit test-and-skip: one request per cycle, registered result one
// cycle later. Assumes inputs are stable in the request cycle.
module bt_test_skip #(
    parameter int HALF_W = 18,
    localparam int WORD_W = 2 * HALF_W,
    localparam int OP_W   = bt_pkg::OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] acc_in,
    input  logic [HALF_W-1:0] ea_in,
    input  logic [WORD_W-1:0] mem_in,
    input  logic [OP_W-1:0]   op_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] acc_out,
    output logic              acc_we,
    output logic              skip_out
);
    import bt_pkg::*;

    op_t               op;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] acc_next;
    logic              we_next;
    logic              skip_next;

    assign op = op_t'(op_in);

    bt_mask_gen #(.HALF_W(HALF_W)) u_mask (
        .src  (op.src),
        .ea   (ea_in),
        .mem  (mem_in),
        .mask (mask)
    );

    bt_modify #(.WORD_W(WORD_W)) u_mod (
        .md     (op.md),
        .acc    (acc_in),
        .mask   (mask),
        .result (acc_next),
        .writes (we_next)
    );

    bt_skip_eval #(.WORD_W(WORD_W)) u_skip (
        .cond (op.cond),
        .acc  (acc_in),
        .mask (mask),
        .skip (skip_next)
    );

    // Register the result of a request; strobes drop when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            acc_out   <= '0;
            acc_we    <= 1'b0;
            skip_out  <= 1'b0;
        end else if (req_valid) begin
            out_valid <= 1'b1;
            acc_out   <= acc_next;
            acc_we    <= we_next;
            skip_out  <= skip_next;
        end else begin
            out_valid <= 1'b0;
            acc_we    <= 1'b0;
            skip_out  <= 1'b0;
        end
    end

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> out_valid); // R2
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !out_valid); // R2
    AST_MASK_HI_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && op.src == MSRC_ADDR_HI) |-> (mask[HALF_W-1:0] == '0)); // R3
    AST_MASK_LO_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && op.src == MSRC_ADDR_LO) |-> (mask[WORD_W-1:HALF_W] == '0)); // R3
    AST_KEEP_PASSES_ACC: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && op.md == MOD_KEEP) |=> (acc_out == $past(acc_in))); // R4
    AST_WE_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n) acc_we |-> out_valid); // R5
    AST_NEVER_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && op.cond == SKC_NEVER) |=> !skip_out); // R6
    AST_IDLE_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> ($stable(acc_out) && !acc_we && !skip_out)); // R8

endmodule

// File: tb/bt_test_skip_tb.sv
module bt_test_skip_tb;
    localparam int HW = 18;
    localparam int WW = 36;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [WW-1:0] acc_in;
    logic [HW-1:0] ea_in;
    logic [WW-1:0] mem_in;
    logic [5:0]    op_in;
    logic          out_valid;
    logic [WW-1:0] acc_out;
    logic          acc_we;
    logic          skip_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    bt_test_skip u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_in(acc_in),
        .ea_in(ea_in), .mem_in(mem_in), .op_in(op_in), .out_valid(out_valid),
        .acc_out(acc_out), .acc_we(acc_we), .skip_out(skip_out)
    );

    function automatic logic [WW-1:0] exp_mask(logic [1:0] s, logic [HW-1:0] ea, logic [WW-1:0] m);
        case (s)
            2'd0:    return {ea, {HW{1'b0}}};
            2'd1:    return {{HW{1'b0}}, ea};
            2'd2:    return m;
            default: return {m[HW-1:0], m[WW-1:HW]};
        endcase
    endfunction

    function automatic logic [WW-1:0] exp_acc(logic [1:0] md, logic [WW-1:0] a, logic [WW-1:0] k);
        case (md)
            2'd0:    return a;
            2'd1:    return a & ~k;
            2'd2:    return a | k;
            default: return a ^ k;
        endcase
    endfunction

    function automatic logic exp_skip(logic [1:0] c, logic [WW-1:0] a, logic [WW-1:0] k);
        case (c)
            2'd0:    return 1'b0;
            2'd1:    return 1'b1;
            2'd2:    return (a & k) != '0;
            default: return (a & k) == '0;
        endcase
    endfunction

    task automatic chk(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request at a falling edge, check at the next falling edge
    task automatic run_op(logic [5:0] op, logic [WW-1:0] a, logic [HW-1:0] ea, logic [WW-1:0] m, string tag);
        logic [WW-1:0] k;
        k = exp_mask(op[5:4], ea, m);
        req_valid = 1'b1; op_in = op; acc_in = a; ea_in = ea; mem_in = m;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R2 valid"}, {35'b0, out_valid}, 36'd1);
        chk({tag, " R4 acc"},   acc_out, exp_acc(op[3:2], a, k));
        chk({tag, " R5 we"},    {35'b0, acc_we}, {35'b0, op[3:2] != 2'd0});
        chk({tag, " R7 skip"},  {35'b0, skip_out}, {35'b0, exp_skip(op[1:0], a, k)});
    endtask

    function automatic logic [WW-1:0] rnd36();
        logic [63:0] t;
        t = {$urandom, $urandom};
        return t[WW-1:0];
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [WW-1:0] held;
        void'($urandom(32'd1234));
        rst_n = 1'b0; req_valid = 1'b0; acc_in = '1; ea_in = '1; mem_in = '1; op_in = '1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {35'b0, out_valid}, 36'd0);
        chk("R1 acc",   acc_out, 36'd0);
        chk("R1 we",    {35'b0, acc_we}, 36'd0);
        chk("R1 skip",  {35'b0, skip_out}, 36'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 each mask source, seen through set-bits on a zero accumulator
        run_op(6'b00_10_00, 36'd0, 18'h2A5A5, 36'h0, "R3 addr-hi");
        chk("R3 addr-hi mask", acc_out, {18'h2A5A5, 18'h0});
        run_op(6'b01_10_00, 36'd0, 18'h2A5A5, 36'h0, "R3 addr-lo");
        chk("R3 addr-lo mask", acc_out, {18'h0, 18'h2A5A5});
        run_op(6'b10_10_00, 36'd0, 18'h0, 36'h123456789, "R3 mem");
        chk("R3 mem mask", acc_out, 36'h123456789);
        run_op(6'b11_10_00, 36'd0, 18'h0, 36'h123456789, "R3 mem-swap");
        chk("R3 mem-swap mask", acc_out, {18'h16789, 18'h048D1});

        // R4 modifications on a patterned accumulator
        run_op(6'b10_00_00, 36'hF0F0F0F0F, 18'h0, 36'hFF00FF00F, "R4 keep");
        run_op(6'b10_01_00, 36'hF0F0F0F0F, 18'h0, 36'hFF00FF00F, "R4 clear");
        run_op(6'b10_11_00, 36'hFFFFFFFFF, 18'h0, 36'h00000FFFF, "R4 flip");
        // R6 never / always
        run_op(6'b01_00_00, 36'hFFFFFFFFF, 18'h3FFFF, 36'h0, "R6 never");
        run_op(6'b01_00_01, 36'h0, 18'h0, 36'h0, "R6 always");

        // R7 conflict: set bits with skip-when-zero on clear bits -> skip
        run_op(6'b01_10_11, 36'h0, 18'h00F00, 36'h0, "R7 set+zero");
        chk("R7 pre-mod skip", {35'b0, skip_out}, 36'd1);
        // clear bits with skip-when-nonzero on set bits -> skip
        run_op(6'b00_01_10, 36'hFFFFFFFFF, 18'h00001, 36'h0, "R7 clear+any");
        chk("R7 pre-mod skip2", {35'b0, skip_out}, 36'd1);
        // flip with skip-when-nonzero on clear bits -> no skip
        run_op(6'b10_11_10, 36'h0, 18'h0, 36'h800000001, "R7 flip+any");
        chk("R7 pre-mod noskip", {35'b0, skip_out}, 36'd0);

        // R9 zero mask under each modification and zero/nonzero tests
        for (int md = 0; md < 4; md++) begin
            run_op({2'b10, 2'(md), 2'b11}, 36'h5A5A5A5A5, 18'h3FFFF, 36'h0, "R9 zero-mask");
            chk("R9 acc unchanged", acc_out, 36'h5A5A5A5A5);
            chk("R9 skip-zero", {35'b0, skip_out}, 36'd1);
        end
        run_op(6'b00_00_10, 36'hFFFFFFFFF, 18'h0, 36'hFFFFFFFFF, "R9 zero-mask any");
        chk("R9 skip-any", {35'b0, skip_out}, 36'd0);

        // R8 idle: strobes low and result held
        run_op(6'b10_10_01, 36'h0, 18'h0, 36'hABCDE1234, "R8 pre");
        held = acc_out;
        acc_in = rnd36(); mem_in = rnd36(); op_in = 6'b10_11_01;
        @(negedge clk);
        chk("R8 valid", {35'b0, out_valid}, 36'd0);
        chk("R8 we",    {35'b0, acc_we}, 36'd0);
        chk("R8 skip",  {35'b0, skip_out}, 36'd0);
        chk("R8 held",  acc_out, held);

        // Constrained random across all 64 codes, back-to-back requests
        for (int i = 0; i < 400; i++) begin
            logic [5:0]    op;
            logic [WW-1:0] a, m;
            logic [HW-1:0] ea;
            op = 6'($urandom);
            a  = rnd36();
            m  = ($urandom % 4 == 0) ? (rnd36() & rnd36() & rnd36()) : rnd36();
            ea = 18'($urandom);
            if ($urandom % 5 == 0) a = a & ~exp_mask(op[5:4], ea, m);
            run_op(op, a, ea, m, "rand");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule